// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse-Width Modulator

This block generates up to two pulse-width modulated outputs from one shared input clock. Each channel has three word registers on a simple bus in which reads and writes complete in one cycle. The control word holds a 6-bit clock divider and a stop-style bit. The duty word holds a 10-bit high count and a force-high flag. The period word holds a 10-bit period count. A per-channel enable input starts and stops the waveform. The divider produces one count tick every prescale+1 input cycles. The period counter advances on each tick, and the output is high while the period count is below the duty count.

Programmed values are copied into a per-channel working set only when a channel starts and at each period boundary. Software can therefore rewrite a running channel without producing a truncated pulse. Each channel is driven by a small state machine with three states. In IDLE the output is low and the counters are held at zero. In RUN the channel is counting normally. In DRAIN the enable has been removed but the current period is still being completed. The transitions are named as follows. START goes IDLE to RUN when the enable is seen high. HALT goes from RUN or DRAIN to IDLE when the enable is low and the stop-now bit is set. SOFTSTOP goes RUN to DRAIN when the enable is low and the stop-now bit is clear. EDGESTOP goes from RUN or DRAIN to IDLE at a period boundary with the enable low. RESUME goes DRAIN to RUN at a boundary when the enable has returned.

Top module: `pwmx_top`

## Requirements
- R1: After reset every register reads as zero and every output is low.
- R2: Word addresses are byte offsets. Channel 0 has its control word at 0x00, its duty word at 0x04 and its period word at 0x08. Channel 1 uses the same offsets plus 0x10 and is present only when NUM_CHAN is 2. The control word has the prescale in bits 5:0 and stop-now in bit 6. The duty word has the high count in bits 9:0 and force-high in bit 10. The period word has the period count in bits 9:0. A read returns the last value written, with all other bits zero. Offset 0x0C reads as zero and ignores writes.
- R3: While running, the output period is (prescale+1)*(period+1) input cycles.
- R4: For a high count from 1 to the period count, the output is high for (prescale+1)*high-count cycles of each period.
- R5: With force-high set, the output stays high for the whole period, whatever the high count is.
- R6: A high count greater than the period count gives a constant-high output. A high count of 0 with force-high clear gives a constant-low output.
- R7: With stop-now set, the output is low from the cycle after the enable is sampled low.
- R8: With stop-now clear, removing the enable lets the current period run to its end, after which the output is low.
- R9: New prescale, high-count, force-high and period values take effect only at the next period boundary. The period in progress is completed with the old values.
- R10: The two channels run independently, each from its own registers and enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock shared by bus and counters |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| chan_en | input | NUM_CHAN | Per-channel run enable |
| pwm_out | output | NUM_CHAN | Per-channel waveform |

## Verification
A fault in the divider or period counter changes the spacing of rising edges within the first full period after start. The scoreboard sees this at the next rising edge as a wrong period or high length. A working set that was reloaded at the wrong time makes the period in progress during a rewrite come out with the new lengths, so the check fails one period after the write. A wrong state decision on enable removal shows up as a high run that is too short or too long, measured on the very next cycles after the enable falls.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
    localparam int PS_W     = 6;
    localparam int PV_W     = 10;
    localparam int DC_W     = 10;
    localparam int ADDR_W   = 5;
    localparam int STOP_BIT = 6;
    localparam int FULL_BIT = 10;
    localparam int USED_W   = FULL_BIT + 1;

    localparam logic [1:0] WORD_CTRL = 2'd0;
    localparam logic [1:0] WORD_DUTY = 2'd1;
    localparam logic [1:0] WORD_PER  = 2'd2;

    typedef struct packed {
        logic            stop_now;
        logic [PS_W-1:0] ps;
        logic            full;
        logic [DC_W-1:0] dc;
        logic [PV_W-1:0] pv;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } chan_state_e;
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int NUM_CHAN = 2,
    parameter int DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output chan_cfg_t             cfg_o [NUM_CHAN]
);
    logic [1:0] word;
    logic       aligned;
    chan_cfg_t  cfg_q [NUM_CHAN];
    logic       unused_hi;

    assign word      = addr[3:2];
    assign aligned   = (addr[1:0] == 2'b00);
    assign unused_hi = ^wdata[DATA_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CHAN; c++) cfg_q[c] <= '0;
        end else if (sel && wr && aligned) begin
            for (int c = 0; c < NUM_CHAN; c++) begin
                if (int'(addr[4]) == c) begin
                    unique case (word)
                        WORD_CTRL: begin
                            cfg_q[c].stop_now <= wdata[STOP_BIT];
                            cfg_q[c].ps       <= wdata[PS_W-1:0];
                        end
                        WORD_DUTY: begin
                            cfg_q[c].full <= wdata[FULL_BIT];
                            cfg_q[c].dc   <= wdata[DC_W-1:0];
                        end
                        WORD_PER:  cfg_q[c].pv <= wdata[PV_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr && aligned) begin
            for (int c = 0; c < NUM_CHAN; c++) begin
                if (int'(addr[4]) == c) begin
                    unique case (word)
                        WORD_CTRL: rdata = DATA_W'({cfg_q[c].stop_now, cfg_q[c].ps});
                        WORD_DUTY: rdata = DATA_W'({cfg_q[c].full, cfg_q[c].dc});
                        WORD_PER:  rdata = DATA_W'(cfg_q[c].pv);
                        default:   rdata = '0;
                    endcase
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_CHAN; g++) begin : g_out
            assign cfg_o[g] = cfg_q[g];
        end
    endgenerate

    p_rd_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |-> (rdata[DATA_W-1:USED_W] == '0));

    p_idle_bus_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == '0));
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
    import pwmx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);
    chan_state_e     state, nxt;
    chan_cfg_t       sh;
    logic [PS_W-1:0] ps_cnt;
    logic [PV_W-1:0] pr_cnt;
    logic            tick, wrap, load;
    logic            unused_sh;

    assign tick      = (ps_cnt == sh.ps);
    assign wrap      = tick && (pr_cnt == sh.pv);
    assign unused_sh = sh.stop_now;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (en_i) nxt = ST_RUN;
            ST_RUN: begin
                if (!en_i && cfg_i.stop_now) nxt = ST_IDLE;
                else if (!en_i && wrap)      nxt = ST_IDLE;
                else if (!en_i)              nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!en_i && cfg_i.stop_now) nxt = ST_IDLE;
                else if (wrap)               nxt = en_i ? ST_RUN : ST_IDLE;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    assign load = ((state == ST_IDLE) && (nxt == ST_RUN)) ||
                  ((state != ST_IDLE) && wrap && (nxt != ST_IDLE));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // working set, reloaded only at start and at period boundaries
    always_ff @(posedge clk) begin
        if (!rst_n)    sh <= '0;
        else if (load) sh <= cfg_i;
    end

    // prescale and period counters
    always_ff @(posedge clk) begin
        if (!rst_n || nxt == ST_IDLE || load) begin
            ps_cnt <= '0;
            pr_cnt <= '0;
        end else if (tick) begin
            ps_cnt <= '0;
            pr_cnt <= pr_cnt + 1'b1;
        end else begin
            ps_cnt <= ps_cnt + 1'b1;
        end
    end

    // output process
    always_comb begin
        unique case (state)
            ST_RUN, ST_DRAIN: pwm_o = sh.full || (pr_cnt < sh.dc);
            default:          pwm_o = 1'b0;
        endcase
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> ((ps_cnt <= sh.ps) && (pr_cnt <= sh.pv)));

    p_stop_now_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_i) && cfg_i.stop_now) |=> !pwm_o);

    p_drain_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DRAIN) && !wrap && !cfg_i.stop_now) |=> (state == ST_DRAIN));

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !wrap) |=> $stable(sh));

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pr_cnt == '0));
endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
    import pwmx_pkg::*;
#(
    parameter int NUM_CHAN = 2,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_CHAN-1:0] chan_en,
    output logic [NUM_CHAN-1:0] pwm_out
);
    chan_cfg_t cfg [NUM_CHAN];

    pwmx_regs #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg_o (cfg)
    );

    generate
        for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
            pwmx_chan u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (chan_en[g]),
                .cfg_i (cfg[g]),
                .pwm_o (pwm_out[g])
            );
        end
    endgenerate

    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pwm_out == '0));
endmodule

// File: tb/pwmx_top_tb.sv
`timescale 1ns/1ps
module pwmx_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  chan_en = '0;
    logic [1:0]  pwm_out;

    int total = 0, bad = 0, cyc = 0;
    bit arm = 0;
    int unsigned q_hi[$], q_per[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    pwmx_top #(.NUM_CHAN(2), .DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_en(chan_en), .pwm_out(pwm_out)
    );

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor: measures channel 0 pulses between rising edges
    bit started = 0, prev = 0;
    int unsigned hi = 0, per = 0;
    always @(negedge clk) begin
        automatic bit o = pwm_out[0];
        if (!arm) started = 0;
        else if (!started) begin
            if (o && !prev) begin started = 1; hi = 1; per = 1; end
        end else if (o && !prev) begin
            if (q_hi.size() > 0) begin
                automatic int unsigned eh = q_hi.pop_front();
                automatic int unsigned ep = q_per.pop_front();
                automatic string tg = q_tag.pop_front();
                chk({tg, " period"}, per, ep);
                chk({tg, " high"}, hi, eh);
            end
            hi = 1; per = 1;
        end else begin
            per++;
            if (o) hi++;
        end
        prev = o;
    end

    task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bread(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic push(string tg, int unsigned h, int unsigned p, int n);
        for (int i = 0; i < n; i++) begin
            q_hi.push_back(h); q_per.push_back(p); q_tag.push_back(tg);
        end
    endtask

    task automatic drain_q(string tg);
        int t = 0;
        while (q_hi.size() != 0 && t < 5000) begin @(negedge clk); t++; end
        if (q_hi.size() != 0) begin
            chk({tg, " scoreboard drained"}, q_hi.size(), 0);
            q_hi.delete(); q_per.delete(); q_tag.delete();
        end
    endtask

    task automatic cfg0(bit stop, int ps, bit full, int dc, int pv);
        bwrite(5'h00, 32'((int'(stop) << 6) | ps));
        bwrite(5'h04, 32'((int'(full) << 10) | dc));
        bwrite(5'h08, 32'(pv));
    endtask

    task automatic run_sb(string tg, int ps, int pv, int dc, int n);
        cfg0(1, ps, 0, dc, pv);
        arm = 1;
        @(posedge clk); #1; chan_en[0] = 1;
        push(tg, (ps + 1) * dc, (ps + 1) * (pv + 1), n);
        drain_q(tg);
        arm = 0; chan_en[0] = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic count_high(int ch, int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); if (pwm_out[ch]) c++; end
    endtask

    task automatic stop_test(string tg, bit stop, int exp);
        int n = 0, t = 0;
        cfg0(stop, 1, 1, 0, 9);
        @(posedge clk); #1; chan_en[0] = 1;
        while (n < 5) begin @(negedge clk); if (pwm_out[0]) n++; end
        @(posedge clk); #1; chan_en[0] = 0;
        forever begin
            @(negedge clk);
            if (!pwm_out[0] || t > 300) break;
            n++; t++;
        end
        chk(tg, n, exp);
        repeat (30) @(posedge clk);
    endtask

    initial begin
        logic [31:0] d;
        int c;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 outputs low after reset", pwm_out, 0);
        foreach (d[i]) if (i < 6) begin
            automatic logic [4:0] a = 5'((i / 3) * 16 + (i % 3) * 4);
            bread(a, d);
            chk("R1 register zero after reset", d, 0);
        end

        // R2 field masks and map
        bwrite(5'h00, 32'hFFFF_FFFF); bread(5'h00, d); chk("R2 ctrl mask", d, 32'h7F);
        bwrite(5'h04, 32'hFFFF_FFFF); bread(5'h04, d); chk("R2 duty mask", d, 32'h7FF);
        bwrite(5'h08, 32'hFFFF_FFFF); bread(5'h08, d); chk("R2 period mask", d, 32'h3FF);
        bwrite(5'h10, 32'hFFFF_FF85); bread(5'h10, d); chk("R2 ch1 ctrl at 0x10", d, 32'h05);
        bread(5'h14, d); chk("R2 ch1 duty untouched", d, 0);
        bwrite(5'h0C, 32'hFFFF_FFFF); bread(5'h0C, d); chk("R2 hole reads zero", d, 0);
        bwrite(5'h10, 0);

        // R3 / R4 period and high time
        run_sb("R3R4 ps1 pv9 dc3", 1, 9, 3, 3);
        run_sb("R3R4 ps0 pv4 dc1", 0, 4, 1, 3);
        run_sb("R3R4 ps3 pv2 dc2", 3, 2, 2, 3);
        run_sb("R4 dc equals pv", 0, 7, 7, 3);
        run_sb("R3 max prescale", 63, 1, 1, 2);

        // R5 force-high, R6 constant levels
        cfg0(1, 0, 1, 2, 9);
        @(posedge clk); #1; chan_en[0] = 1;
        repeat (5) @(posedge clk);
        count_high(0, 40, c); chk("R5 force-high constant", c, 40);
        chan_en[0] = 0; repeat (3) @(posedge clk);
        cfg0(1, 0, 0, 10, 9);
        @(posedge clk); #1; chan_en[0] = 1;
        repeat (5) @(posedge clk);
        count_high(0, 40, c); chk("R6 dc above pv constant high", c, 40);
        chan_en[0] = 0; repeat (3) @(posedge clk);
        cfg0(1, 0, 0, 0, 9);
        @(posedge clk); #1; chan_en[0] = 1;
        repeat (5) @(posedge clk);
        count_high(0, 40, c); chk("R6 dc zero constant low", c, 0);
        chan_en[0] = 0; repeat (3) @(posedge clk);

        // R7 immediate stop, R8 finish period
        stop_test("R7 stop-now high cycles", 1, 6);
        stop_test("R8 soft stop high cycles", 0, 20);

        // R9 update at period boundary
        cfg0(1, 0, 0, 4, 9);
        arm = 1;
        @(posedge clk); #1; chan_en[0] = 1;
        push("R9 before write", 4, 10, 2);
        drain_q("R9");
        bwrite(5'h04, 32'd2);
        bwrite(5'h08, 32'd4);
        push("R9 period in progress", 4, 10, 1);
        push("R9 after boundary", 2, 5, 2);
        drain_q("R9");
        arm = 0; chan_en[0] = 0;
        repeat (3) @(posedge clk);

        // R10 independent channels
        cfg0(1, 0, 0, 5, 9);
        bwrite(5'h10, 32'h40);
        bwrite(5'h14, 32'd1);
        bwrite(5'h18, 32'd3);
        @(posedge clk); #1; chan_en = 2'b11;
        repeat (6) @(posedge clk);
        count_high(1, 40, c); chk("R10 ch1 high count", c, 10);
        count_high(0, 40, c); chk("R10 ch0 high count", c, 20);
        chan_en = 2'b00;
        repeat (3) @(negedge clk);
        chk("R7 both outputs low after stop", pwm_out, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule